// File: doc/BRIEF.md
# Supply-Loss Access Guard with Weak-Cell Write Swallow

This block sits between an asynchronous SRAM control bus (chip select, output enable and write strobe, all active low) and the memory array behind it. From the three strobes it decodes read and write cycles. It produces the write enable for the array and the enable for the data-bus drivers. While the supply is reported as failing, the block deselects the array entirely. After the supply returns, it keeps the array locked out until the bus has been quiet for a programmable recovery time, counted on the system clock.

The block also samples a battery-low indication at the moment the supply comes back. If the battery is low, a sticky flag is set. The flag silently discards the next write cycle and clears itself when that cycle ends, so software can detect the weak cell by writing a value and reading it back.

Top module: `pwr_write_guard`

## Requirements
- R1: `dq_oe` is high only in a cycle where the guard is unlocked, `pfail` is low, `ce_n` is low, `oe_n` is low and `we_n` is high.
- R2: In the unlocked state with the weak-cell flag clear, `arr_we` is high exactly while `ce_n` and `we_n` are both low. The write starts at the later of the two falling strobes and ends at the earlier of the two rising strobes.
- R3: A low `we_n` forces `dq_oe` low even when `ce_n` and `oe_n` are both low.
- R4: While `pfail` is high, `arr_we` and `dq_oe` are low in that same cycle, whatever the strobes do.
- R5: The first clock edge that sees `pfail` low after an outage is the power-up edge. After it, no access is recognized until REC_CYCLES further edges have each seen `ce_n` or `we_n` high. An edge that sees both low restarts the count.
- R6: If `pfail` rises again during the recovery count, the count is discarded and starts over after the next power-up edge.
- R7: `batt_low` is sampled only on the power-up edge. A 1 sets the weak-cell flag and a 0 clears it. Its value at any other time has no effect.
- R8: While the weak-cell flag is set, the first write cycle in the unlocked state keeps `arr_we` low for its whole duration. The flag clears on the first edge after that cycle ends, so the following write reaches the array.
- R9: A write that is in progress when `pfail` rises is cut off: `arr_we` drops in the same cycle.
- R10: While `rst_n` is low, `arr_we` and `dq_oe` are low and the guard is in the powered-off state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the recovery counter and the flag |
| rst_n | input | 1 | Active-low asynchronous reset; puts the guard in the powered-off state |
| pfail | input | 1 | High while the supply is out of tolerance |
| batt_low | input | 1 | High when the backup cell is weak; sampled at power-up |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| arr_we | output | 1 | Write enable passed to the memory array |
| dq_oe | output | 1 | Enable for the data-bus output drivers |

## Verification
All eight combinations of the three strobes are applied in the unlocked state. This separates the read drive, the write enable and the case where the write strobe overrides output enable. Staggered strobe orderings show that a write opens on the later falling strobe and closes on the earlier rising one. The recovery lockout is probed one edge before and one edge after its end. It is probed once after a write attempt restarts the count and once after a brief supply drop restarts it. The weak-cell flag is shown both by a write that does not reach the array followed by one that does, and by a power-up with a good cell where the first write passes.

// File: rtl/pwr_guard_pkg.sv
package pwr_guard_pkg;
   typedef enum logic [1:0] {
      PG_OFF     = 2'd0,
      PG_RECOVER = 2'd1,
      PG_ACTIVE  = 2'd2
   } pg_state_t;
endpackage

// File: rtl/pg_recovery_timer.sv
module pg_recovery_timer
   import pwr_guard_pkg::*;
#(
   parameter int unsigned REC_CYCLES = 200000
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      pfail,
   input  logic      bus_idle,
   output pg_state_t state,
   output logic      power_up
);
   localparam int unsigned CNT_W = $clog2(REC_CYCLES + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(REC_CYCLES - 1);

   logic [CNT_W-1:0] cnt;

   assign power_up = (state == PG_OFF) && !pfail;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= PG_OFF;
         cnt   <= '0;
      end else if (pfail) begin
         state <= PG_OFF;
         cnt   <= '0;
      end else begin
         unique case (state)
            PG_OFF: begin
               state <= PG_RECOVER;
               cnt   <= '0;
            end
            PG_RECOVER: begin
               if (!bus_idle) begin
                  cnt <= '0;
               end else if (cnt == LAST) begin
                  state <= PG_ACTIVE;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: begin
               state <= PG_ACTIVE;
               cnt   <= '0;
            end
         endcase
      end
   end
endmodule

// File: rtl/pg_batt_flag.sv
module pg_batt_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic power_up,
   input  logic batt_low,
   input  logic wr_cycle,
   output logic weak_flag
);
   logic wr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         weak_flag <= 1'b0;
         wr_q      <= 1'b0;
      end else begin
         wr_q <= wr_cycle;
         if (power_up) begin
            weak_flag <= batt_low;
         end else if (wr_q && !wr_cycle) begin
            weak_flag <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/pg_access_decode.sv
module pg_access_decode (
   input  logic unlocked,
   input  logic pfail,
   input  logic ce_n,
   input  logic oe_n,
   input  logic we_n,
   input  logic weak_flag,
   output logic wr_cycle,
   output logic arr_we,
   output logic dq_oe
);
   logic live;

   always_comb begin
      live     = unlocked && !pfail && !ce_n;
      wr_cycle = live && !we_n;
      arr_we   = wr_cycle && !weak_flag;
      dq_oe    = live && we_n && !oe_n;
   end
endmodule

// File: rtl/pwr_write_guard.sv
module pwr_write_guard
   import pwr_guard_pkg::*;
#(
   parameter int unsigned REC_CYCLES    = 200000,
   parameter bit          BATT_GUARD_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pfail,
   input  logic batt_low,
   input  logic ce_n,
   input  logic oe_n,
   input  logic we_n,
   output logic arr_we,
   output logic dq_oe
);
   pg_state_t state;
   logic      power_up;
   logic      weak_flag;
   logic      wr_cycle;
   logic      bus_idle;

   if (REC_CYCLES < 1) begin : g_bad_rec
      $error("REC_CYCLES must be at least 1");
   end

   assign bus_idle = ce_n || we_n;

   pg_recovery_timer #(.REC_CYCLES(REC_CYCLES)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .pfail    (pfail),
      .bus_idle (bus_idle),
      .state    (state),
      .power_up (power_up)
   );

   if (BATT_GUARD_EN) begin : g_flag
      pg_batt_flag u_flag (
         .clk       (clk),
         .rst_n     (rst_n),
         .power_up  (power_up),
         .batt_low  (batt_low),
         .wr_cycle  (wr_cycle),
         .weak_flag (weak_flag)
      );
   end else begin : g_noflag
      assign weak_flag = 1'b0;
   end

   pg_access_decode u_dec (
      .unlocked  (state == PG_ACTIVE),
      .pfail     (pfail),
      .ce_n      (ce_n),
      .oe_n      (oe_n),
      .we_n      (we_n),
      .weak_flag (weak_flag),
      .wr_cycle  (wr_cycle),
      .arr_we    (arr_we),
      .dq_oe     (dq_oe)
   );
endmodule

// File: rtl/pg_guard_chk.sv
module pg_guard_chk #(
   parameter int unsigned REC_CYCLES = 200000
) (
   input logic clk,
   input logic rst_n,
   input logic pfail,
   input logic ce_n,
   input logic oe_n,
   input logic we_n,
   input logic arr_we,
   input logic dq_oe
);
   localparam int unsigned SW = $clog2(REC_CYCLES + 2) + 1;
   logic [SW-1:0] since_pf;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        since_pf <= '0;
      else if (pfail)                    since_pf <= '0;
      else if (since_pf <= SW'(REC_CYCLES)) since_pf <= since_pf + 1'b1;
   end

   // R1
   read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> (!ce_n && !oe_n && we_n && !pfail));
   // R2
   write_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arr_we |-> (!ce_n && !we_n));
   // R3
   we_blocks_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |-> !dq_oe);
   // R4
   pfail_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pfail |-> (!arr_we && !dq_oe));
   // R5
   lockout_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_we || dq_oe) |-> (since_pf >= SW'(REC_CYCLES)));
   // R9
   wr_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_we && $rose(pfail)) |-> 1'b0);
endmodule

bind pwr_write_guard pg_guard_chk #(.REC_CYCLES(REC_CYCLES)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .pfail  (pfail),
   .ce_n   (ce_n),
   .oe_n   (oe_n),
   .we_n   (we_n),
   .arr_we (arr_we),
   .dq_oe  (dq_oe)
);

// File: tb/test_pwr_write_guard.sv
module test_pwr_write_guard;
   localparam int unsigned REC = 8;

   logic clk = 1'b0;
   logic rst_n, pfail, batt_low, ce_n, oe_n, we_n;
   logic arr_we, dq_oe;
   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   pwr_write_guard #(.REC_CYCLES(REC), .BATT_GUARD_EN(1'b1)) i_pwr_write_guard (
      .clk(clk), .rst_n(rst_n), .pfail(pfail), .batt_low(batt_low),
      .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .arr_we(arr_we), .dq_oe(dq_oe)
   );

   // {ce_n, oe_n, we_n, expected arr_we, expected dq_oe}
   localparam logic [4:0] VEC [8] = '{
      5'b000_10, 5'b001_01, 5'b010_10, 5'b011_00,
      5'b100_00, 5'b101_00, 5'b110_00, 5'b111_00
   };

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic bus(input logic c, input logic o, input logic w);
      ce_n = c; oe_n = o; we_n = w;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 0; pfail = 1; batt_low = 0; bus(1, 1, 1);
      repeat (2) @(negedge clk);
      #2;
      chk("R10 arr_we in reset", arr_we, 0);
      chk("R10 dq_oe in reset", dq_oe, 0);

      // R4: supply failing, strobes active
      @(negedge clk); rst_n = 1; bus(0, 0, 0);
      #2 chk("R4 arr_we under pfail", arr_we, 0);
      repeat (3) @(negedge clk);
      bus(0, 0, 1);
      #2 chk("R4 dq_oe under pfail", dq_oe, 0);

      // power returns with weak cell
      @(negedge clk); bus(1, 1, 1); batt_low = 1; pfail = 0;
      @(negedge clk); batt_low = 0;             // power-up edge passed
      repeat (3) @(negedge clk);
      bus(0, 1, 0);
      #2 chk("R5 write during lockout", arr_we, 0);
      repeat (2) @(negedge clk);
      bus(1, 1, 1);                             // count restarts from here
      repeat (7) @(negedge clk);
      bus(0, 0, 1);
      #2 chk("R5 read one edge before unlock", dq_oe, 0);
      @(negedge clk);
      #2 chk("R5 read after unlock", dq_oe, 1);

      // R8: first write swallowed
      @(negedge clk); bus(0, 1, 0);
      #2 chk("R8 first write blocked", arr_we, 0);
      repeat (3) @(negedge clk);
      #2 chk("R8 still blocked mid-cycle", arr_we, 0);
      @(negedge clk); bus(0, 1, 1);
      @(negedge clk); batt_low = 1; bus(0, 1, 0);
      #2 chk("R8 second write passes", arr_we, 1);
      chk("R7 batt_low ignored while unlocked", arr_we, 1);
      @(negedge clk); bus(1, 1, 1);

      // R1 R2 R3: strobe table
      for (int i = 0; i < 8; i++) begin
         @(negedge clk); bus(VEC[i][4], VEC[i][3], VEC[i][2]);
         #2;
         chk("R2 table arr_we", arr_we, VEC[i][1]);
         chk((i == 0 || i == 2) ? "R3 table dq_oe" : "R1 table dq_oe", dq_oe, VEC[i][0]);
      end

      // R2: ordering of strobes
      @(negedge clk); bus(0, 1, 1);
      #2 chk("R2 ce only", arr_we, 0);
      @(negedge clk); bus(0, 1, 0);
      #2 chk("R2 later we fall starts", arr_we, 1);
      @(negedge clk); bus(1, 1, 0);
      #2 chk("R2 ce rise ends", arr_we, 0);
      @(negedge clk); bus(0, 1, 0);
      #2 chk("R2 later ce fall starts", arr_we, 1);
      @(negedge clk); bus(0, 1, 1);
      #2 chk("R2 we rise ends", arr_we, 0);

      // R9: write cut by supply loss
      @(negedge clk); bus(0, 1, 0);
      #2 chk("R9 write before loss", arr_we, 1);
      @(negedge clk); pfail = 1;
      #2 chk("R9 write cut same cycle", arr_we, 0);
      @(negedge clk); bus(0, 0, 1);
      #2 chk("R4 read cut under pfail", dq_oe, 0);

      // R6: drop during recovery restarts count, good cell this time
      @(negedge clk); bus(1, 1, 1); batt_low = 0; pfail = 0;
      repeat (5) @(negedge clk);
      pfail = 1;
      @(negedge clk); pfail = 0;
      @(negedge clk);                           // power-up edge passed
      repeat (7) @(negedge clk);
      bus(0, 0, 1);
      #2 chk("R6 locked one edge before end", dq_oe, 0);
      @(negedge clk);
      #2 chk("R6 unlocked after restart", dq_oe, 1);
      @(negedge clk); bus(0, 1, 0);
      #2 chk("R7 good cell first write passes", arr_we, 1);
      @(negedge clk); bus(1, 1, 1);

      // R10: reset mid-operation
      @(negedge clk); bus(0, 0, 1); rst_n = 0;
      #2 chk("R10 reset drops drive", dq_oe, 0);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule